// File: doc/BRIEF.md
# Transmit Preemption Gate and Hold Control

This block sits on the transmit side of a MAC that carries two traffic classes: express frames, which must never wait long, and preemptable frames, which may be split into fragments. It watches the preemptable stream beat by beat and decides, cycle by cycle, whether the frame now in flight may be cut so that pending express traffic can go out. A cut is allowed only when the current fragment has reached the minimum fragment size. It is also allowed only when the bytes still to send are at least the minimum size picked by a 2-bit code. After a cut, the frame stays open in a suspended state. It resumes as a continuation fragment once express traffic has cleared.

The preemptable side is a valid/ready stream. `pre_valid` offers a beat, `pre_ready` is the gate, and a beat moves only in a cycle where both are high. The source must hold a beat, with its `pre_sop`, `pre_eop` and `pre_frame_len` qualifiers, until it is accepted. `pre_ready` drops for three reasons: the hold request is high, a cut is being taken this cycle, or the frame is suspended while express traffic is still pending. The datapath supplies `pre_sent_bytes`, the count of bytes of the current frame already accepted. That count is 0 on the start beat. The block also emits one-cycle pulses for frame starts, continuation fragments and rising edges of the hold request, plus a 2-bit fragment sequence number.

Top module: `tx_preempt_ctrl`

## Requirements
- R1: The code `cfg_frag_code` sets the minimum remaining size: 0 gives 64 bytes, 1 gives 128, 2 gives 192 and 3 gives 256. `preempt_now` may be high only when the latched frame length minus `pre_sent_bytes` is at least that size.
- R2: `pre_frame_len` is captured on the accepted beat that has `pre_sop` high. Later changes to that input do not affect the decision for the open frame.
- R3: `preempt_now` is high only when all of these hold: `exp_pending` is high, a frame is open and not suspended, and at least 64 bytes of the current fragment have been sent.
- R4: While `preempt_now` is high, `pre_ready` is low. In the next cycle the frame is suspended: `preempt_now` is low, and `pre_ready` stays low until `exp_pending` falls.
- R5: While `cfg_hold` is high, `pre_ready` is low and no preemptable beat is accepted.
- R6: `st_hold_pulse` is high for exactly the one cycle after `cfg_hold` goes from 0 to 1, and at no other time.
- R7: `st_start_pulse` is high for the one cycle after a beat with `pre_sop` is accepted while no frame is open. After reset, all pulses and `preempt_now` are low and `pre_ready` is high.
- R8: The first beat accepted after a cut makes `st_cont_pulse` high for one cycle and adds 1, modulo 4, to `frag_seq`. `frag_seq` returns to 0 when a new frame starts.
- R9: While `cfg_enable` is low, `preempt_now` stays low and the frame flows without interruption.
- R10: A frame whose length is less than the coded minimum size plus 64 bytes is never cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Allows preemption when high |
| cfg_hold | input | 1 | Hold request; blocks all preemptable beats |
| cfg_frag_code | input | 2 | Minimum remaining-size code |
| exp_pending | input | 1 | Express traffic is waiting |
| pre_valid | input | 1 | Preemptable beat offered |
| pre_ready | output | 1 | Preemptable beat may be accepted |
| pre_sop | input | 1 | Beat is the first of a frame |
| pre_eop | input | 1 | Beat is the last of a frame |
| pre_frame_len | input | LEN_W | Frame length in bytes, valid with `pre_sop` |
| pre_sent_bytes | input | LEN_W | Bytes of the current frame already accepted |
| preempt_now | output | 1 | Cut the preemptable frame this cycle |
| frag_seq | output | SEQ_W | Fragment sequence number of the open frame |
| st_start_pulse | output | 1 | A preemptable frame started |
| st_cont_pulse | output | 1 | A continuation fragment started |
| st_hold_pulse | output | 1 | The hold request rose |

## Verification
The assertions take several things about the inputs as given. `pre_sent_bytes` follows the bytes the source has actually had accepted for the open frame. It never exceeds the latched length, and it does not move backwards within a frame. `pre_sop` is offered only when no frame is open. The directed stimulus keeps to these rules: it sets the byte count by hand to each boundary value, starts frames only after closing the previous one, and clears express pending before ending a frame. Under these rules, a cut always leaves the source with a valid fragment boundary.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Progress of the preemptable frame through the arbiter.
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,  // no frame open
    PS_ACTIVE = 2'd1,  // fragment being sent
    PS_SUSP   = 2'd2   // frame cut, waiting to resume
  } pstate_e;

endpackage

// File: rtl/tpc_hold_edge.sv
module tpc_hold_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_in,
  output logic rise_pulse
);

  logic hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      rise_pulse <= 1'b0;
    end else begin
      hold_q     <= hold_in;
      rise_pulse <= hold_in & ~hold_q;
    end
  end

endmodule

// File: rtl/tpc_cut_decide.sv
module tpc_cut_decide
  import tpc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CODE_W    = 2,
  parameter int FRAG_UNIT = 64
) (
  input  pstate_e           state,
  input  logic              en,
  input  logic              exp_pend,
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  len_q,
  input  logic [LEN_W-1:0]  base_q,
  input  logic [LEN_W-1:0]  sent,
  output logic              cut
);

  localparam int XW = LEN_W + 1;

  logic [XW-1:0] remain_b;
  logic [XW-1:0] frag_b;
  logic [XW-1:0] min_b;
  logic          frag_ok;
  logic          remain_ok;

  always_comb begin
    // Bytes left in the frame; saturate at zero on a malformed count.
    remain_b = (len_q >= sent) ? {1'b0, len_q - sent} : '0;
    // Bytes sent since the current fragment began.
    frag_b   = (sent >= base_q) ? {1'b0, sent - base_q} : '0;
    // Coded minimum: (code + 1) fragment units.
    min_b    = XW'(FRAG_UNIT) * (XW'(code) + XW'(1));
    frag_ok   = frag_b >= XW'(FRAG_UNIT);
    remain_ok = remain_b >= min_b;
    cut = (state == PS_ACTIVE) && en && exp_pend && frag_ok && remain_ok;
  end

endmodule

// File: rtl/tpc_frag_track.sv
module tpc_frag_track
  import tpc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SEQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sop,
  input  logic             eop,
  input  logic             cut,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] sent,
  output pstate_e          state,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] base_q,
  output logic [SEQ_W-1:0] seq_q,
  output logic             start_p,
  output logic             cont_p
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PS_IDLE;
      len_q   <= '0;
      base_q  <= '0;
      seq_q   <= '0;
      start_p <= 1'b0;
      cont_p  <= 1'b0;
    end else begin
      start_p <= 1'b0;
      cont_p  <= 1'b0;
      unique case (state)
        PS_IDLE: begin
          if (fire && sop) begin
            len_q   <= frame_len;
            base_q  <= '0;
            seq_q   <= '0;
            start_p <= 1'b1;
            state   <= eop ? PS_IDLE : PS_ACTIVE;
          end
        end
        PS_ACTIVE: begin
          if (cut) begin
            state <= PS_SUSP;
          end else if (fire && eop) begin
            state <= PS_IDLE;
          end
        end
        PS_SUSP: begin
          if (fire) begin
            base_q <= sent;
            seq_q  <= seq_q + SEQ_W'(1);
            cont_p <= 1'b1;
            state  <= eop ? PS_IDLE : PS_ACTIVE;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_preempt_ctrl.sv
module tx_preempt_ctrl
  import tpc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int SEQ_W     = 2,
  parameter int CODE_W    = 2,
  parameter int FRAG_UNIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_hold,
  input  logic [CODE_W-1:0] cfg_frag_code,
  input  logic              exp_pending,
  input  logic              pre_valid,
  output logic              pre_ready,
  input  logic              pre_sop,
  input  logic              pre_eop,
  input  logic [LEN_W-1:0]  pre_frame_len,
  input  logic [LEN_W-1:0]  pre_sent_bytes,
  output logic              preempt_now,
  output logic [SEQ_W-1:0]  frag_seq,
  output logic              st_start_pulse,
  output logic              st_cont_pulse,
  output logic              st_hold_pulse
);

  pstate_e          state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] base_q;
  logic             cut;
  logic             fire;

  tpc_cut_decide #(
    .LEN_W    (LEN_W),
    .CODE_W   (CODE_W),
    .FRAG_UNIT(FRAG_UNIT)
  ) u_decide (
    .state   (state),
    .en      (cfg_enable),
    .exp_pend(exp_pending),
    .code    (cfg_frag_code),
    .len_q   (len_q),
    .base_q  (base_q),
    .sent    (pre_sent_bytes),
    .cut     (cut)
  );

  // Gate for the preemptable stream.
  always_comb begin
    unique case (state)
      PS_ACTIVE: pre_ready = !cfg_hold && !cut;
      PS_SUSP:   pre_ready = !cfg_hold && !exp_pending;
      default:   pre_ready = !cfg_hold;
    endcase
  end

  assign fire        = pre_valid && pre_ready;
  assign preempt_now = cut;

  tpc_frag_track #(
    .LEN_W(LEN_W),
    .SEQ_W(SEQ_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .sop      (pre_sop),
    .eop      (pre_eop),
    .cut      (cut),
    .frame_len(pre_frame_len),
    .sent     (pre_sent_bytes),
    .state    (state),
    .len_q    (len_q),
    .base_q   (base_q),
    .seq_q    (frag_seq),
    .start_p  (st_start_pulse),
    .cont_p   (st_cont_pulse)
  );

  tpc_hold_edge u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_in   (cfg_hold),
    .rise_pulse(st_hold_pulse)
  );

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int LEN_W     = 16,
  parameter int SEQ_W     = 2,
  parameter int FRAG_UNIT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             cfg_hold,
  input logic             exp_pending,
  input logic             pre_ready,
  input logic [LEN_W-1:0] pre_sent_bytes,
  input logic             preempt_now,
  input logic [SEQ_W-1:0] frag_seq,
  input logic             st_start_pulse,
  input logic             st_cont_pulse,
  input logic             st_hold_pulse
);

  // R3
  cut_needs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_now |-> (exp_pending && cfg_enable &&
                     pre_sent_bytes >= LEN_W'(FRAG_UNIT)));

  // R4
  cut_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_now |-> !pre_ready);

  // R4
  cut_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_now |=> !preempt_now);

  // R5
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> !pre_ready);

  // R6
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_hold) |=> st_hold_pulse);

  // R6
  hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_hold_pulse |=> !st_hold_pulse);

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_cont_pulse |-> frag_seq == SEQ_W'($past(frag_seq) + SEQ_W'(1)));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_start_pulse, st_cont_pulse}));

endmodule

bind tx_preempt_ctrl tpc_checker #(
  .LEN_W    (LEN_W),
  .SEQ_W    (SEQ_W),
  .FRAG_UNIT(FRAG_UNIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_hold      (cfg_hold),
  .exp_pending   (exp_pending),
  .pre_ready     (pre_ready),
  .pre_sent_bytes(pre_sent_bytes),
  .preempt_now   (preempt_now),
  .frag_seq      (frag_seq),
  .st_start_pulse(st_start_pulse),
  .st_cont_pulse (st_cont_pulse),
  .st_hold_pulse (st_hold_pulse)
);

// File: tb/tx_preempt_ctrl_tb.sv
`timescale 1ns/1ps
module tx_preempt_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_hold, exp_pending;
  logic [1:0]  cfg_frag_code;
  logic        pre_valid, pre_ready, pre_sop, pre_eop;
  logic [15:0] pre_frame_len, pre_sent_bytes;
  logic        preempt_now;
  logic [1:0]  frag_seq;
  logic        st_start_pulse, st_cont_pulse, st_hold_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tx_preempt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_hold(cfg_hold),
    .cfg_frag_code(cfg_frag_code), .exp_pending(exp_pending),
    .pre_valid(pre_valid), .pre_ready(pre_ready), .pre_sop(pre_sop),
    .pre_eop(pre_eop), .pre_frame_len(pre_frame_len),
    .pre_sent_bytes(pre_sent_bytes), .preempt_now(preempt_now),
    .frag_seq(frag_seq), .st_start_pulse(st_start_pulse),
    .st_cont_pulse(st_cont_pulse), .st_hold_pulse(st_hold_pulse)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Set byte count and express flag mid-cycle, then look at the decision.
  task automatic probe(int sent_v, bit exp_v, int want, string req);
    pre_sent_bytes = 16'(sent_v);
    exp_pending    = exp_v;
    #0.2;
    check(req, "preempt_now", int'(preempt_now), want);
  endtask

  task automatic open_frame(int len);
    @(negedge clk);
    exp_pending = 1'b0; pre_valid = 1'b1; pre_sop = 1'b1;
    pre_frame_len = 16'(len); pre_sent_bytes = '0;
    @(negedge clk);
    pre_valid = 1'b0; pre_sop = 1'b0;
    #0.2;
    check("R7", "start pulse", int'(st_start_pulse), 1);
    check("R8", "seq at start", int'(frag_seq), 0);
  endtask

  // Called in the half-cycle in which a cut was seen; resumes the frame.
  task automatic resume(int sent_v, int want_seq);
    @(negedge clk);
    #0.2;
    check("R4", "cut after suspend", int'(preempt_now), 0);
    check("R4", "ready while express", int'(pre_ready), 0);
    exp_pending = 1'b0;
    #0.2;
    check("R4", "ready after express", int'(pre_ready), 1);
    pre_valid = 1'b1; pre_sent_bytes = 16'(sent_v);
    @(negedge clk);
    pre_valid = 1'b0;
    #0.2;
    check("R8", "cont pulse", int'(st_cont_pulse), 1);
    check("R8", "frag seq", int'(frag_seq), want_seq);
  endtask

  task automatic close_frame(int sent_v);
    @(negedge clk);
    exp_pending = 1'b0; pre_valid = 1'b1; pre_eop = 1'b1;
    pre_sent_bytes = 16'(sent_v);
    @(negedge clk);
    pre_valid = 1'b0; pre_eop = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_hold = 1'b0; exp_pending = 1'b0;
    cfg_frag_code = 2'd0; pre_valid = 1'b0; pre_sop = 1'b0; pre_eop = 1'b0;
    pre_frame_len = '0; pre_sent_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.2;
    check("R7", "reset ready", int'(pre_ready), 1);
    check("R7", "reset cut", int'(preempt_now), 0);
    check("R7", "reset pulses",
          int'({st_start_pulse, st_cont_pulse, st_hold_pulse}), 0);
    check("R8", "reset seq", int'(frag_seq), 0);
  endtask

  task automatic t_basic_cut();
    cfg_frag_code = 2'd0;
    open_frame(300);
    @(negedge clk);
    probe(63, 1'b1, 0, "R3");   // fragment below 64 bytes
    probe(64, 1'b0, 0, "R3");   // no express waiting
    probe(237, 1'b1, 0, "R1");  // 63 left, below 64
    probe(236, 1'b1, 1, "R1");  // 64 left
    check("R4", "ready during cut", int'(pre_ready), 0);
    resume(236, 1);
    @(negedge clk);
    #0.2;
    check("R8", "cont pulse one cycle", int'(st_cont_pulse), 0);
    probe(236, 1'b1, 0, "R3");  // new fragment has 0 bytes
    close_frame(300);
  endtask

  task automatic t_codes();
    cfg_frag_code = 2'd3;       // 256 bytes
    open_frame(400);
    @(negedge clk);
    probe(145, 1'b1, 0, "R1");
    probe(144, 1'b1, 1, "R1");
    resume(144, 1);
    close_frame(400);
    cfg_frag_code = 2'd2;       // 192 bytes
    open_frame(300);
    @(negedge clk);
    probe(109, 1'b1, 0, "R1");
    probe(108, 1'b1, 1, "R1");
    resume(108, 1);
    close_frame(300);
    cfg_frag_code = 2'd1;       // 128 bytes, 191 < 128+64
    open_frame(191);
    @(negedge clk);
    probe(64, 1'b1, 0, "R10");
    probe(100, 1'b1, 0, "R10");
    close_frame(191);
    open_frame(192);            // exactly 128+64
    @(negedge clk);
    probe(64, 1'b1, 1, "R10");
    resume(64, 1);
    close_frame(192);
  endtask

  task automatic t_latch();
    cfg_frag_code = 2'd0;
    open_frame(300);
    @(negedge clk);
    pre_frame_len = 16'd9999;
    probe(237, 1'b1, 0, "R2");
    probe(236, 1'b1, 1, "R2");
    resume(236, 1);
    close_frame(300);
  endtask

  task automatic t_enable();
    cfg_frag_code = 2'd0;
    cfg_enable = 1'b0;
    open_frame(300);
    @(negedge clk);
    probe(100, 1'b1, 0, "R9");
    check("R9", "ready while disabled", int'(pre_ready), 1);
    @(negedge clk);
    #0.2;
    check("R9", "no cut next cycle", int'(preempt_now), 0);
    cfg_enable = 1'b1;
    #0.2;
    check("R9", "cut when enabled", int'(preempt_now), 1);
    resume(100, 1);
    close_frame(300);
  endtask

  task automatic t_wrap();
    int base = 0;
    cfg_frag_code = 2'd0;
    open_frame(2000);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      probe(base + 64, 1'b1, 1, "R8");
      resume(base + 64, i % 4);
      base += 64;
    end
    close_frame(2000);
  endtask

  task automatic t_hold();
    @(negedge clk);
    cfg_hold = 1'b1; pre_valid = 1'b1; pre_sop = 1'b1;
    pre_frame_len = 16'd300; pre_sent_bytes = '0;
    #0.2;
    check("R5", "ready under hold", int'(pre_ready), 0);
    @(negedge clk);
    #0.2;
    check("R6", "hold pulse", int'(st_hold_pulse), 1);
    check("R5", "no start under hold", int'(st_start_pulse), 0);
    @(negedge clk);
    #0.2;
    check("R6", "hold pulse once", int'(st_hold_pulse), 0);
    check("R5", "still no start", int'(st_start_pulse), 0);
    cfg_hold = 1'b0;
    @(negedge clk);
    pre_valid = 1'b0; pre_sop = 1'b0;
    #0.2;
    check("R7", "start after release", int'(st_start_pulse), 1);
    check("R6", "no pulse on fall", int'(st_hold_pulse), 0);
    cfg_hold = 1'b1;
    @(negedge clk);
    #0.2;
    check("R6", "second rise pulse", int'(st_hold_pulse), 1);
    cfg_hold = 1'b0;
    close_frame(300);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_cut();
    t_codes();
    t_latch();
    t_enable();
    t_wrap();
    t_hold();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule